// File: doc/BRIEF.md
# Programmable YUV to RGB Colour-Space Converter

This block turns a stream of studio-range luma and chroma samples into full-range red, green and blue pixels. It takes one 8-bit Y, U and V triple per cycle on a valid/ready stream and returns one 8-bit R, G and B triple per accepted input. The result comes out three clock edges after the input is accepted. A stall at the output holds every pipeline stage at once.

Each output channel comes from a programmable row of a 3x4 matrix. A row holds three signed multipliers at a scale of 1024 and one signed offset at a scale of 16. The offset is moved up six bits so that it sits on the same 1024 scale. The sum is rounded by adding 512, shifted down by ten bits and saturated to 0..255.

Twelve matrix words are loaded through a single-cycle write port. After reset they hold a BT.601 studio-to-full-range set: the luma gain is about 1.164, V adds about 1.596 to red, U adds about 2.018 to blue, and green loses about 0.391 of U and 0.813 of V. The datapath is a three-stage pipeline (products, sum, saturate) with a shared advance enable. It has no state machine.

Top module: `yuv2rgb_conv`

## Requirements
- R1: For each channel, out = clamp(floor((kY*Y + kU*U + kV*V + ofs*64 + 512) / 1024)). Y, U and V are taken as unsigned. kY, kU and kV are 13-bit two's complement and ofs is 14-bit two's complement.
- R2: Write address a (0..11) selects row a/4, where row 0 is green, row 1 is red and row 2 is blue. Within a row, field a%4 selects 0=kY, 1=kU, 2=kV, 3=ofs. A multiplier takes cfg_data[12:0] and an offset takes cfg_data[13:0]. A write with cfg_we high takes effect on the next clock edge.
- R3: After reset the words are, row by row: green 0x4A7, 0x1E6F, 0x1CBF, 0x877; red 0x4A7, 0x000, 0x662, 0x3211; blue 0x4A7, 0x812, 0x000, 0x2EB1. With these words, Y=16, U=V=128 gives (0,0,0) and Y=235, U=V=128 gives (255,255,255).
- R4: With out_ready held high, a triple accepted at one rising edge appears on the outputs with out_valid high after the third rising edge, counting the accepting edge.
- R5: While out_valid is high and out_ready is low, in_ready is low and out_valid, out_r, out_g and out_b hold their values. While out_valid is low, in_ready is high.
- R6: A write to addresses 12..15 changes no coefficient.
- R7: During and straight after reset, out_valid is low and in_ready is high.
- R8: Every accepted triple produces exactly one output triple, in order, under any pattern of stalls.
- R9: A sum below 0 gives 0 and a sum above 255 gives 255 on that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input triple present |
| in_ready | output | 1 | Converter accepts the input this cycle |
| in_y | input | 8 | Luma sample |
| in_u | input | 8 | Blue-difference sample |
| in_v | input | 8 | Red-difference sample |
| out_valid | output | 1 | Output triple present |
| out_ready | input | 1 | Downstream accepts the output |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 4 | Coefficient word address |
| cfg_data | input | 14 | Coefficient word value |

## Verification
The hardest case to reach is a stall that lands while the pipeline is only partly full. Data must then neither be lost nor duplicated when the stages restart together. The bench reaches it by sweeping a 16x16x16 grid of triples while drawing out_ready at random at several densities, and it scores every output against an integer model. The saturation corners come from inputs outside the studio range. Changes to the matrix are checked by reloading all twelve words with a non-default matrix, and by writing to the unused addresses and then streaming again.

// File: rtl/csc_pkg.sv
package csc_pkg;
    localparam int PIX_W     = 8;
    localparam int K_W       = 13;
    localparam int OFS_W     = 14;
    localparam int FRAC      = 10;
    localparam int OFS_SHIFT = 6;
    localparam int NCH       = 3;   // 0 = green, 1 = red, 2 = blue
    localparam int FIELDS    = 4;   // kY, kU, kV, ofs
    localparam int ADDR_W    = 4;
    localparam int STAGES    = 3;

    typedef struct packed {
        logic signed [K_W-1:0]   ky;
        logic signed [K_W-1:0]   ku;
        logic signed [K_W-1:0]   kv;
        logic signed [OFS_W-1:0] ofs;
    } row_t;

    function automatic row_t reset_row(input int ch);
        row_t r;
        unique case (ch)
            0:       r = '{ky: 13'h04A7, ku: 13'h1E6F, kv: 13'h1CBF, ofs: 14'h0877};
            1:       r = '{ky: 13'h04A7, ku: 13'h0000, kv: 13'h0662, ofs: 14'h3211};
            default: r = '{ky: 13'h04A7, ku: 13'h0812, kv: 13'h0000, ofs: 14'h2EB1};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
    import csc_pkg::*;
#(
    parameter int N_ROWS = NCH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [OFS_W-1:0]      cfg_data,
    output row_t [N_ROWS-1:0]     rows
);
    localparam int FSEL_W = $clog2(FIELDS);

    logic [ADDR_W-FSEL_W-1:0] row_sel;
    logic [FSEL_W-1:0]        fld_sel;

    always_comb begin
        row_sel = cfg_addr[ADDR_W-1:FSEL_W];
        fld_sel = cfg_addr[FSEL_W-1:0];
    end

    for (genvar g = 0; g < N_ROWS; g++) begin : g_row
        row_t row_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q <= reset_row(g);
            end else if (cfg_we && (row_sel == (ADDR_W-FSEL_W)'(g))) begin
                unique case (fld_sel)
                    2'd0:    row_q.ky  <= cfg_data[K_W-1:0];
                    2'd1:    row_q.ku  <= cfg_data[K_W-1:0];
                    2'd2:    row_q.kv  <= cfg_data[K_W-1:0];
                    default: row_q.ofs <= cfg_data;
                endcase
            end
        end

        assign rows[g] = row_q;
    end
endmodule

// File: rtl/csc_pipe_ctl.sv
module csc_pipe_ctl
    import csc_pkg::*;
#(
    parameter int N_STG = STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic adv,
    output logic out_valid
);
    logic [N_STG-1:0] vld_q;

    always_comb begin
        adv       = out_ready || !vld_q[N_STG-1];
        out_valid = vld_q[N_STG-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (adv) begin
            vld_q <= {vld_q[N_STG-2:0], in_valid};
        end
    end
endmodule

// File: rtl/csc_channel.sv
module csc_channel
    import csc_pkg::*;
#(
    parameter int P_W = PIX_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    input  row_t           row,
    input  logic [P_W-1:0] y,
    input  logic [P_W-1:0] u,
    input  logic [P_W-1:0] v,
    output logic [P_W-1:0] pix
);
    localparam int PROD_W = K_W + P_W + 1;
    localparam int ACC_W  = PROD_W + 3;
    localparam logic signed [ACC_W-1:0] ROUND = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAXV  = (ACC_W'(1) <<< P_W) - ACC_W'(1);

    logic signed [PROD_W-1:0] py_q, pu_q, pv_q;
    logic signed [ACC_W-1:0]  ofs_q, ofs_ext, acc_q, scaled;
    logic [P_W-1:0]           pix_q, sat;

    always_comb begin
        ofs_ext = ACC_W'($signed(row.ofs)) <<< OFS_SHIFT;
        scaled  = acc_q >>> FRAC;
        if (scaled < 0)         sat = '0;
        else if (scaled > MAXV) sat = '1;
        else                    sat = scaled[P_W-1:0];
    end

    // stage 1: products and aligned offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            py_q  <= '0;
            pu_q  <= '0;
            pv_q  <= '0;
            ofs_q <= '0;
        end else if (adv) begin
            py_q  <= $signed(row.ky) * $signed({1'b0, y});
            pu_q  <= $signed(row.ku) * $signed({1'b0, u});
            pv_q  <= $signed(row.kv) * $signed({1'b0, v});
            ofs_q <= ofs_ext;
        end
    end

    // stage 2: sum with rounding bias
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (adv) begin
            acc_q <= ACC_W'(py_q) + ACC_W'(pu_q) + ACC_W'(pv_q) + ofs_q + ROUND;
        end
    end

    // stage 3: scale down and saturate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else if (adv) begin
            pix_q <= sat;
        end
    end

    assign pix = pix_q;
endmodule

// File: rtl/yuv2rgb_conv.sv
module yuv2rgb_conv
    import csc_pkg::*;
#(
    parameter int P_W = PIX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [P_W-1:0]    in_y,
    input  logic [P_W-1:0]    in_u,
    input  logic [P_W-1:0]    in_v,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [P_W-1:0]    out_r,
    output logic [P_W-1:0]    out_g,
    output logic [P_W-1:0]    out_b,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [OFS_W-1:0]  cfg_data
);
    row_t [NCH-1:0]        rows;
    logic                  adv;
    logic [NCH-1:0][P_W-1:0] pix;

    csc_coef_bank #(.N_ROWS(NCH)) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .rows(rows)
    );

    csc_pipe_ctl #(.N_STG(STAGES)) u_ctl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .out_ready(out_ready), .adv(adv), .out_valid(out_valid)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        csc_channel #(.P_W(P_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .adv(adv), .row(rows[c]),
            .y(in_y), .u(in_u), .v(in_v), .pix(pix[c])
        );
    end

    always_comb begin
        in_ready = adv;
        out_g    = pix[0];
        out_r    = pix[1];
        out_b    = pix[2];
    end
endmodule

// File: rtl/csc_checker.sv
module csc_checker #(
    parameter int P_W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic           out_valid,
    input logic           out_ready,
    input logic [P_W-1:0] out_r,
    input logic [P_W-1:0] out_g,
    input logic [P_W-1:0] out_b
);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b));

    p_stall_blocks_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    p_empty_accepts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) ##1 in_ready ##1 in_ready |=> out_valid);

    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_idle_r7: assert (!out_valid);
        end
    end
endmodule

bind yuv2rgb_conv csc_checker #(.P_W(P_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
);

// File: tb/sim_yuv2rgb_conv.sv
module sim_yuv2rgb_conv;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, out_ready = 1'b1, cfg_we = 1'b0;
    logic       in_ready, out_valid;
    logic [7:0] in_y = '0, in_u = '0, in_v = '0, out_r, out_g, out_b;
    logic [3:0] cfg_addr = '0;
    logic [13:0] cfg_data = '0;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int coefw[12];
    int src_q[$];
    int exp_q[$];

    yuv2rgb_conv u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_y(in_y), .in_u(in_u), .in_v(in_v), .out_valid(out_valid),
        .out_ready(out_ready), .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL R8 watchdog expired: act=%0d exp=%0d cycles", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%06h exp=%06h", req, act, exp);
        end
    endtask

    function automatic int sx(input int w, input int bits);
        return (w >= (1 << (bits - 1))) ? w - (1 << bits) : w;
    endfunction

    function automatic int raw(input int ch, input int y, input int u, input int v);
        int b = ch * 4;
        return sx(coefw[b], 13) * y + sx(coefw[b+1], 13) * u + sx(coefw[b+2], 13) * v
               + sx(coefw[b+3], 14) * 64 + 512;
    endfunction

    function automatic int chan(input int ch, input int y, input int u, input int v);
        int s = raw(ch, y, u, v) >>> 10;
        if (s < 0) return 0;
        if (s > 255) return 255;
        return s;
    endfunction

    function automatic int model(input int p);
        int y = (p >> 16) & 255, u = (p >> 8) & 255, v = p & 255;
        return (chan(1, y, u, v) << 16) | (chan(0, y, u, v) << 8) | chan(2, y, u, v);
    endfunction

    function automatic bit clips(input int p);
        int y = (p >> 16) & 255, u = (p >> 8) & 255, v = p & 255;
        for (int c = 0; c < 3; c++) begin
            int s = raw(c, y, u, v) >>> 10;
            if (s < 0 || s > 255) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic int pk(input int y, input int u, input int v);
        return (y << 16) | (u << 8) | v;
    endfunction

    task automatic run_stream(input int pct_ready, input string tag);
        int sent = 0;
        int n = src_q.size();
        int e;
        while (sent < n || exp_q.size() > 0) begin
            @(negedge clk);
            out_ready = ($urandom_range(99) < pct_ready);
            in_valid  = (sent < n);
            if (sent < n) {in_y, in_u, in_v} = src_q[sent][23:0];
            #1;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, {tag, " R8 extra output"}, {out_r, out_g, out_b}, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk({out_r, out_g, out_b} == e[23:0], tag, {out_r, out_g, out_b}, e);
                end
            end
            if (in_valid && in_ready) begin
                exp_q.push_back(model(src_q[sent]));
                sent++;
            end
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        src_q.delete();
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a[3:0]; cfg_data = d[13:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        int lat;
        int e;
        coefw = '{'h4A7, 'h1E6F, 'h1CBF, 'h877, 'h4A7, 'h000, 'h662, 'h3211,
                  'h4A7, 'h812, 'h000, 'h2EB1};
        repeat (3) @(negedge clk);
        // R7: state held in reset
        chk(out_valid == 1'b0, "R7 out_valid in reset", out_valid, 0);
        chk(in_ready == 1'b1, "R7 in_ready in reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 out_valid after reset", out_valid, 0);

        // R4: latency, single triple with out_ready high
        in_valid = 1'b1; {in_y, in_u, in_v} = {8'd235, 8'd128, 8'd128};
        @(negedge clk);
        in_valid = 1'b0; lat = 1;
        while (!out_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 3, "R4 latency", lat, 3);
        // R3: white through reset matrix
        chk({out_r, out_g, out_b} == 24'hFFFFFF, "R3 white", {out_r, out_g, out_b}, 24'hFFFFFF);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 single output", out_valid, 0);

        // R3: black through reset matrix
        src_q.push_back(pk(16, 128, 128));
        e = model(pk(16, 128, 128));
        chk(e == 0, "R3 black model", e, 0);
        run_stream(100, "R3 black");

        // R1: colour bars, full rate and stalled
        src_q = '{pk(210,16,146), pk(170,166,16), pk(145,54,34), pk(106,202,222),
                  pk(81,90,240), pk(41,240,110), pk(235,128,128), pk(16,128,128)};
        run_stream(100, "R1 bars");
        src_q = '{pk(210,16,146), pk(170,166,16), pk(145,54,34), pk(106,202,222),
                  pk(81,90,240), pk(41,240,110)};
        run_stream(40, "R1 bars stalled");

        // R9: inputs outside studio range drive both clamp limits
        src_q = '{pk(0,0,0), pk(255,255,255), pk(255,0,255), pk(0,255,0), pk(255,255,0)};
        foreach (src_q[i]) chk(clips(src_q[i]), "R9 stimulus saturates", src_q[i], 1);
        run_stream(100, "R9 clamp");

        // R8 / R5 / R1: grid sweep under random backpressure
        for (int y = 0; y < 256; y += 17)
            for (int u = 0; u < 256; u += 17)
                for (int v = 0; v < 256; v += 17)
                    src_q.push_back(pk(y, u, v));
        run_stream(60, "R8 sweep stalled");

        // R5: hold under long stall
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; {in_y, in_u, in_v} = {8'd81, 8'd90, 8'd240};
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(out_valid && !in_ready, "R5 stall blocks input", {out_valid, in_ready}, 2);
        chk({out_r, out_g, out_b} == model(pk(81,90,240)), "R5 held data",
            {out_r, out_g, out_b}, model(pk(81,90,240)));
        out_ready = 1'b1;
        @(negedge clk);
        chk(!out_valid && in_ready, "R5 drained", {out_valid, in_ready}, 1);

        // R6: writes beyond word 11 are ignored
        for (int a = 12; a < 16; a++) wr(a, 'h1FFF);
        src_q = '{pk(235,128,128), pk(16,128,128), pk(145,54,34), pk(41,240,110)};
        run_stream(100, "R6 unused address");

        // R2: load a new matrix, row order G, R, B and field order kY, kU, kV, ofs
        coefw = '{512, 0, 0, 160, 0, 0, 1024, 0, 0, 'h1C00, 0, 'hFF0};
        for (int a = 0; a < 12; a++) wr(a, coefw[a]);
        src_q = '{pk(100, 50, 30), pk(200, 0, 255), pk(0, 77, 0)};
        e = model(pk(100, 50, 30));
        chk(e == {8'd30, 8'd60, 8'd205}, "R2 model check", e, {8'd30, 8'd60, 8'd205});
        run_stream(100, "R2 reload");
        for (int y = 0; y < 256; y += 51)
            for (int u = 0; u < 256; u += 51)
                for (int v = 0; v < 256; v += 51)
                    src_q.push_back(pk(y, u, v));
        run_stream(70, "R2 reload sweep");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule